// File: doc/BRIEF.md
# Hotplug Slot Command Executor

This block runs the command engine of a hot-plug controller that looks after up to 31 expansion slots. Software writes a command code byte and a target byte, each through its own byte enable. When either byte is written, the engine runs the command on the next clock edge. For a byte that was not written in that access, it uses the value already stored.

Each slot has three 2-bit fields: slot state, power indicator and attention indicator. Each slot also has a retention-latch-open flag, a 2-bit card presence field and two latched events, one for the latch and one for presence. Commands can do four things:
- rewrite the fields of one slot;
- select the bus speed mode;
- power all slots;
- enable all slots.

The result appears in a 4-bit command status word. A sticky command-detected flag is set when any command completes. Card insertion is modelled as a per-slot strobe. Clear strobes are provided for the latched events and for the detected flag.

Top module: `slot_cmd_exec`

## Requirements
- R1: After reset, every slot is in state disabled (3) with both indicators off (3), latch open (1), presence empty (3) and no latched events. The status word is 0 and the detected flag is 0.
- R2: Codes 0x00–0x3F are single-slot commands. Bits [1:0] give the new state (0 no change, 1 power only, 2 enabled, 3 disabled). Bits [3:2] give the new power indicator and bits [5:4] the new attention indicator (0 no change, 1 on, 2 blink, 3 off). A field left at 0 keeps its value.
- R3: The target is a 5-bit logical slot number, and logical N selects slot index N-1. A target of 0, or a target above NUM_SLOTS, sets invalid-command (status bit 2) and changes no slot.
- R4: A single-slot command that requests power only (1) on a slot that is currently enabled (2) is rejected. It sets status bit 2 and changes nothing.
- R5: The status bits are [0] busy, [1] latch open, [2] invalid command and [3] invalid mode. Each new command clears all four and then sets only those bits that its own outcome calls for. Between commands the status word holds its value.
- R6: Codes 0x40–0x47 select the bus speed from code bits [2:0]. Only value 0 is accepted. Any other value sets invalid-mode (status bit 3).
- R7: Code 0x48 (power all) and code 0x49 (enable all) fail with status bit 2, and change no slot, if any slot is in state enabled.
- R8: When an all-slot command is accepted, each slot whose latch is closed takes state 1 (for 0x48) or state 2 (for 0x49), with the power indicator on. Each slot whose latch is open gets the power indicator off and keeps its state. Attention indicators do not change.
- R9: A slot is turned off when a single-slot command requests state 3 and power indicator 3, and the slot was not already disabled with power indicator off. The slot then gets latch open, presence 3, and both its latch and presence events latched.
- R10: The detected flag is set by every command, including rejected ones, and it stays set. The clear strobe resets it, except in a cycle where a command runs; there the set wins.
- R11: A command runs only on a write whose byte enables include the code byte or the target byte. A write with no byte enable set runs nothing and stores nothing.
- R12: Codes 0x4A–0xFF set status bit 2 and change no slot.
- R13: An insertion strobe closes the slot's latch, sets presence to 0 and latches both events. An event clear strobe clears both events of its slot, unless an event is being set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_be | input | 2 | Byte enables: [0] code byte, [1] target byte |
| cmd_code | input | 8 | Command code byte |
| cmd_target | input | 8 | Target byte (bits [4:0] used) |
| det_clr | input | 1 | Clears the command-detected flag |
| card_insert | input | NUM_SLOTS | Per-slot insertion strobe |
| evt_clr | input | NUM_SLOTS | Per-slot latched event clear |
| slot_state | output | 2*NUM_SLOTS | Slot state, slot i at [2i+1:2i] |
| pwr_ind | output | 2*NUM_SLOTS | Power indicator per slot |
| attn_ind | output | 2*NUM_SLOTS | Attention indicator per slot |
| latch_open | output | NUM_SLOTS | Retention latch open per slot |
| presence | output | 2*NUM_SLOTS | Presence field per slot |
| evt_latch | output | NUM_SLOTS | Latched latch-change event |
| evt_pres | output | NUM_SLOTS | Latched presence event |
| cmd_status | output | 4 | Command status word |
| cmd_detected | output | 1 | Command-detected flag |

## Verification
The assertions assume that a write strobe always comes with byte enables and a code that are defined, with no X or Z values. They also take the target byte's upper three bits as don't-care. The bench holds every input at a defined value from time zero, including the reset cycles. It drives each stimulus for exactly one clock and then returns all strobes to 0. In its random phase it draws codes that reach every command class and the undefined range, and targets that include 0 and values above the slot count.

// File: rtl/slot_cmd_pkg.sv
package slot_cmd_pkg;
  localparam logic [1:0] FLD_KEEP  = 2'd0;
  localparam logic [1:0] ST_PWR    = 2'd1;
  localparam logic [1:0] ST_EN     = 2'd2;
  localparam logic [1:0] ST_DIS    = 2'd3;
  localparam logic [1:0] IND_ON    = 2'd1;
  localparam logic [1:0] IND_OFF   = 2'd3;
  localparam logic [1:0] PRES_EMPTY = 2'd3;
  localparam logic [1:0] PRES_LOW   = 2'd0;

  typedef enum logic [2:0] {OP_SLOT, OP_SPEED, OP_PWR_ALL, OP_EN_ALL, OP_BAD} op_e;

  function automatic op_e classify(input logic [7:0] code);
    if (code[7:6] == 2'b00)          return OP_SLOT;
    else if (code[7:3] == 5'b01000)  return OP_SPEED;
    else if (code == 8'h48)          return OP_PWR_ALL;
    else if (code == 8'h49)          return OP_EN_ALL;
    else                             return OP_BAD;
  endfunction

  function automatic logic is_off(input logic [1:0] st, input logic [1:0] pw);
    return (st == ST_DIS) && (pw == IND_OFF);
  endfunction

  function automatic logic [1:0] merge_fld(input logic [1:0] old_v, input logic [1:0] req);
    return (req == FLD_KEEP) ? old_v : req;
  endfunction
endpackage

// File: rtl/slot_cmd_decode.sv
module slot_cmd_decode
  import slot_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 31
) (
  input  logic                 exec,
  input  logic [7:0]           code,
  input  logic [4:0]           tgt,
  input  logic [1:0]           tgt_state,
  input  logic                 any_enabled,
  output logic [NUM_SLOTS-1:0] sel,
  output logic                 all_go,
  output logic [1:0]           all_state,
  output logic                 bad_cmd,
  output logic                 bad_mode,
  output logic                 tgt_valid
);
  localparam logic [4:0] MAX_TGT = 5'(NUM_SLOTS);

  op_e  op;
  logic reject_pwr;
  logic single_ok;
  logic is_all;

  always_comb begin
    op         = classify(code);
    tgt_valid  = (tgt != 5'd0) && (tgt <= MAX_TGT);
    reject_pwr = (tgt_state == ST_EN) && (code[1:0] == ST_PWR);
    single_ok  = exec && (op == OP_SLOT) && tgt_valid && !reject_pwr;
    is_all     = (op == OP_PWR_ALL) || (op == OP_EN_ALL);
    all_go     = exec && is_all && !any_enabled;
    all_state  = (op == OP_PWR_ALL) ? ST_PWR : ST_EN;
    bad_mode   = exec && (op == OP_SPEED) && (code[2:0] != 3'd0);
    bad_cmd    = exec && (((op == OP_SLOT) && !(tgt_valid && !reject_pwr)) ||
                          (is_all && any_enabled) || (op == OP_BAD));
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
    assign sel[i] = single_ok && (tgt == 5'(i + 1));
  end
endmodule

// File: rtl/slot_cell.sv
module slot_cell
  import slot_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply_single,
  input  logic [1:0] req_st,
  input  logic [1:0] req_pw,
  input  logic [1:0] req_at,
  input  logic       apply_all,
  input  logic [1:0] all_st,
  input  logic       insert,
  input  logic       evt_clr,
  output logic [1:0] st_q,
  output logic [1:0] pw_q,
  output logic [1:0] at_q,
  output logic       mrl_q,
  output logic [1:0] pres_q,
  output logic       evm_q,
  output logic       evp_q,
  output logic       off_event
);
  logic [1:0] st_n, pw_n, at_n;
  logic       evt_set;

  assign off_event = apply_single && !is_off(st_q, pw_q) &&
                     (req_st == ST_DIS) && (req_pw == IND_OFF);
  assign evt_set   = off_event || insert;

  always_comb begin
    st_n = st_q;
    pw_n = pw_q;
    at_n = at_q;
    if (apply_single) begin
      st_n = merge_fld(st_q, req_st);
      pw_n = merge_fld(pw_q, req_pw);
      at_n = merge_fld(at_q, req_at);
    end else if (apply_all) begin
      if (!mrl_q) begin
        st_n = all_st;
        pw_n = IND_ON;
      end else begin
        pw_n = IND_OFF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_DIS;
      pw_q   <= IND_OFF;
      at_q   <= IND_OFF;
      mrl_q  <= 1'b1;
      pres_q <= PRES_EMPTY;
      evm_q  <= 1'b0;
      evp_q  <= 1'b0;
    end else begin
      st_q <= st_n;
      pw_q <= pw_n;
      at_q <= at_n;
      if (off_event) begin
        mrl_q  <= 1'b1;
        pres_q <= PRES_EMPTY;
      end else if (insert) begin
        mrl_q  <= 1'b0;
        pres_q <= PRES_LOW;
      end
      evm_q <= (evm_q & ~evt_clr) | evt_set;
      evp_q <= (evp_q & ~evt_clr) | evt_set;
    end
  end

  // R9: a turn-off forces the latch open and the slot empty, and latches both events
  p_off_forces_r9: assert property (@(posedge clk) disable iff (!rst_n)
    off_event |=> (mrl_q && (pres_q == PRES_EMPTY) && evm_q && evp_q));

  // R2: with no command applied, the three control fields keep their values
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply_single || apply_all) |=> ($stable(st_q) && $stable(pw_q) && $stable(at_q)));

  // R13: an insertion without a turn-off closes the latch
  p_insert_closes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (insert && !off_event) |=> (!mrl_q && (pres_q == PRES_LOW)));
endmodule

// File: rtl/slot_cmd_exec.sv
module slot_cmd_exec
  import slot_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 31
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_wr,
  input  logic [1:0]             cmd_be,
  input  logic [7:0]             cmd_code,
  input  logic [7:0]             cmd_target,
  input  logic                   det_clr,
  input  logic [NUM_SLOTS-1:0]   card_insert,
  input  logic [NUM_SLOTS-1:0]   evt_clr,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] pwr_ind,
  output logic [2*NUM_SLOTS-1:0] attn_ind,
  output logic [NUM_SLOTS-1:0]   latch_open,
  output logic [2*NUM_SLOTS-1:0] presence,
  output logic [NUM_SLOTS-1:0]   evt_latch,
  output logic [NUM_SLOTS-1:0]   evt_pres,
  output logic [3:0]             cmd_status,
  output logic                   cmd_detected
);
  logic [7:0]           code_q, eff_code;
  logic [4:0]           tgt_q, eff_tgt;
  logic                 exec;
  logic [1:0]           tgt_state;
  logic                 any_enabled;
  logic [NUM_SLOTS-1:0] sel, is_en, off_ev;
  logic                 all_go, bad_cmd, bad_mode, tgt_valid;
  logic [1:0]           all_state;

  assign exec     = cmd_wr && (cmd_be != 2'b00);
  assign eff_code = cmd_be[0] ? cmd_code : code_q;
  assign eff_tgt  = cmd_be[1] ? cmd_target[4:0] : tgt_q;

  always_comb begin
    tgt_state = FLD_KEEP;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (eff_tgt == 5'(i + 1)) tgt_state = slot_state[2*i +: 2];
  end
  assign any_enabled = |is_en;

  slot_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) dec_i (
    .exec(exec), .code(eff_code), .tgt(eff_tgt), .tgt_state(tgt_state),
    .any_enabled(any_enabled), .sel(sel), .all_go(all_go), .all_state(all_state),
    .bad_cmd(bad_cmd), .bad_mode(bad_mode), .tgt_valid(tgt_valid)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_cell cell_i (
      .clk(clk), .rst_n(rst_n), .apply_single(sel[i]),
      .req_st(eff_code[1:0]), .req_pw(eff_code[3:2]), .req_at(eff_code[5:4]),
      .apply_all(all_go), .all_st(all_state),
      .insert(card_insert[i]), .evt_clr(evt_clr[i]),
      .st_q(slot_state[2*i +: 2]), .pw_q(pwr_ind[2*i +: 2]), .at_q(attn_ind[2*i +: 2]),
      .mrl_q(latch_open[i]), .pres_q(presence[2*i +: 2]),
      .evm_q(evt_latch[i]), .evp_q(evt_pres[i]), .off_event(off_ev[i])
    );
    assign is_en[i] = (slot_state[2*i +: 2] == ST_EN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q       <= 8'h00;
      tgt_q        <= 5'd0;
      cmd_status   <= 4'h0;
      cmd_detected <= 1'b0;
    end else begin
      if (cmd_wr && cmd_be[0]) code_q <= cmd_code;
      if (cmd_wr && cmd_be[1]) tgt_q  <= cmd_target[4:0];
      if (exec) cmd_status <= {bad_mode, bad_cmd, 2'b00};
      cmd_detected <= exec | (cmd_detected & ~det_clr);
    end
  end

  // R10: every executed command raises the detected flag
  p_cmd_detect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> cmd_detected);

  // R5: the status word only changes when a command runs
  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(cmd_status));

  // R4: enabled to power-only is refused
  p_reject_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (eff_code[7:6] == 2'b00) && tgt_valid && (tgt_state == ST_EN) &&
     (eff_code[1:0] == ST_PWR)) |=> (cmd_status[2] && $stable(slot_state)));

  // R7: an all-slot command while a slot is enabled fails
  p_all_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && ((eff_code == 8'h48) || (eff_code == 8'h49)) && any_enabled)
      |=> (cmd_status[2] && $stable(slot_state)));

  // R6: a nonzero speed mode is reported as invalid mode
  p_speed_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (eff_code[7:3] == 5'b01000) && (eff_code[2:0] != 3'd0)) |=> cmd_status[3]);

  // R3: at most one slot is selected by a single-slot command
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: tb/slot_cmd_exec_tb_top.sv
`timescale 1ns/100ps
module slot_cmd_exec_tb_top;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_wr = 1'b0;
  logic [1:0]     cmd_be = 2'b00;
  logic [7:0]     cmd_code = 8'h00;
  logic [7:0]     cmd_target = 8'h00;
  logic           det_clr = 1'b0;
  logic [N-1:0]   card_insert = '0;
  logic [N-1:0]   evt_clr = '0;
  logic [2*N-1:0] slot_state, pwr_ind, attn_ind, presence;
  logic [N-1:0]   latch_open, evt_latch, evt_pres;
  logic [3:0]     cmd_status;
  logic           cmd_detected;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  slot_cmd_exec #(.NUM_SLOTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_be(cmd_be),
    .cmd_code(cmd_code), .cmd_target(cmd_target), .det_clr(det_clr),
    .card_insert(card_insert), .evt_clr(evt_clr),
    .slot_state(slot_state), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
    .latch_open(latch_open), .presence(presence), .evt_latch(evt_latch),
    .evt_pres(evt_pres), .cmd_status(cmd_status), .cmd_detected(cmd_detected)
  );

  // reference model state
  int m_st[N], m_pw[N], m_at[N], m_mrl[N], m_pr[N], m_em[N], m_ep[N];
  int m_status, m_det, m_code, m_tgt;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_st[i] = 3; m_pw[i] = 3; m_at[i] = 3; m_mrl[i] = 1; m_pr[i] = 3;
      m_em[i] = 0; m_ep[i] = 0;
    end
    m_status = 0; m_det = 0; m_code = 0; m_tgt = 0;
  endtask

  task automatic model_step();
    int c, t, s, rs, rp, ra, anyen;
    bit run;
    int off[N];
    run = cmd_wr && (cmd_be != 0);
    c = cmd_be[0] ? int'(cmd_code) : m_code;
    t = cmd_be[1] ? int'(cmd_target[4:0]) : m_tgt;
    for (int i = 0; i < N; i++) off[i] = 0;
    if (run) begin
      m_status = 0;
      if (c < 64) begin
        rs = c % 4; rp = (c / 4) % 4; ra = (c / 16) % 4;
        if (t == 0 || t > N) m_status = 4;
        else begin
          s = t - 1;
          if (m_st[s] == 2 && rs == 1) m_status = 4;
          else begin
            if (!(m_st[s] == 3 && m_pw[s] == 3) && rs == 3 && rp == 3) off[s] = 1;
            if (rs != 0) m_st[s] = rs;
            if (rp != 0) m_pw[s] = rp;
            if (ra != 0) m_at[s] = ra;
          end
        end
      end else if (c < 72) begin
        if (c % 8 != 0) m_status = 8;
      end else if (c == 72 || c == 73) begin
        anyen = 0;
        for (int i = 0; i < N; i++) if (m_st[i] == 2) anyen = 1;
        if (anyen != 0) m_status = 4;
        else for (int i = 0; i < N; i++) begin
          if (m_mrl[i] == 0) begin m_st[i] = (c == 72) ? 1 : 2; m_pw[i] = 1; end
          else m_pw[i] = 3;
        end
      end else m_status = 4;
    end
    m_det = run ? 1 : (det_clr ? 0 : m_det);
    for (int i = 0; i < N; i++) begin
      if (evt_clr[i]) begin m_em[i] = 0; m_ep[i] = 0; end
      if (off[i] != 0 || card_insert[i]) begin m_em[i] = 1; m_ep[i] = 1; end
      if (off[i] != 0) begin m_mrl[i] = 1; m_pr[i] = 3; end
      else if (card_insert[i]) begin m_mrl[i] = 0; m_pr[i] = 0; end
    end
    if (cmd_wr && cmd_be[0]) m_code = int'(cmd_code);
    if (cmd_wr && cmd_be[1]) m_tgt = int'(cmd_target[4:0]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < N; i++) begin
        check(slot_state[2*i +: 2] == m_st[i] && pwr_ind[2*i +: 2] == m_pw[i] &&
              attn_ind[2*i +: 2] == m_at[i], "R2 fields",
              {slot_state[2*i +: 2], pwr_ind[2*i +: 2], attn_ind[2*i +: 2]},
              m_st[i] * 16 + m_pw[i] * 4 + m_at[i]);
        check(latch_open[i] == m_mrl[i] && presence[2*i +: 2] == m_pr[i], "R9/R13 latch+presence",
              {latch_open[i], presence[2*i +: 2]}, m_mrl[i] * 4 + m_pr[i]);
        check(evt_latch[i] == m_em[i] && evt_pres[i] == m_ep[i], "R13 events",
              {evt_latch[i], evt_pres[i]}, m_em[i] * 2 + m_ep[i]);
      end
      check(cmd_status == m_status, "R5 status", cmd_status, m_status);
      check(cmd_detected == m_det, "R10 detected", cmd_detected, m_det);
    end
  end

  // one-cycle stimulus, then all strobes back to 0
  task automatic pulse(input bit wr, input logic [1:0] be, input logic [7:0] code,
                       input logic [7:0] tgt, input logic [N-1:0] ins,
                       input logic [N-1:0] ec, input bit dc);
    @(negedge clk); #0.5;
    cmd_wr = wr; cmd_be = be; cmd_code = code; cmd_target = tgt;
    card_insert = ins; evt_clr = ec; det_clr = dc;
    @(negedge clk); #0.2;
    cmd_wr = 0; cmd_be = 0; card_insert = '0; evt_clr = '0; det_clr = 0;
  endtask

  task automatic cmd(input logic [7:0] code, input logic [7:0] tgt);
    pulse(1'b1, 2'b11, code, tgt, '0, '0, 1'b0);
  endtask

  initial begin
    #5000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk); #0.2;
    // R1 reset state
    check(slot_state == 8'hFF && pwr_ind == 8'hFF && attn_ind == 8'hFF, "R1 fields", slot_state, 8'hFF);
    check(latch_open == 4'hF && presence == 8'hFF && evt_latch == 0, "R1 latch", latch_open, 4'hF);
    check(cmd_status == 0 && cmd_detected == 0, "R1 status", cmd_status, 0);
    cmp_on = 1'b1;

    pulse(1'b0, 2'b00, 8'h00, 8'h00, 4'b0011, '0, 1'b0);
    check(latch_open == 4'b1100 && presence[3:0] == 4'b0000 && evt_latch == 4'b0011, "R13 insert",
          latch_open, 4'b1100);
    pulse(1'b0, 2'b00, 8'h00, 8'h00, '0, 4'b1111, 1'b0);
    check(evt_latch == 0 && evt_pres == 0, "R13 evt clear", evt_latch, 0);

    cmd(8'h19, 8'd1);   // slot0: power only, pwr blink, attn on
    check(slot_state[1:0] == 1 && pwr_ind[1:0] == 2 && attn_ind[1:0] == 1, "R2 single",
          {slot_state[1:0], pwr_ind[1:0], attn_ind[1:0]}, 6'b011001);
    check(cmd_status == 0 && cmd_detected, "R10 detected set", cmd_status, 0);
    cmd(8'h06, 8'd2);   // slot1: enabled, pwr on, attn kept
    check(slot_state[3:2] == 2 && pwr_ind[3:2] == 1 && attn_ind[3:2] == 3, "R2 keep attn",
          attn_ind[3:2], 3);
    cmd(8'h01, 8'd2);
    check(cmd_status == 4'h4 && slot_state[3:2] == 2, "R4 reject", cmd_status, 4);
    cmd(8'h06, 8'd0);
    check(cmd_status == 4'h4, "R3 target zero", cmd_status, 4);
    cmd(8'h06, 8'd5);
    check(cmd_status == 4'h4 && slot_state[7:4] == 4'hF, "R3 target high", cmd_status, 4);
    cmd(8'h40, 8'd1);
    check(cmd_status == 4'h0, "R5 status cleared / R6 mode 0", cmd_status, 0);
    cmd(8'h43, 8'd1);
    check(cmd_status == 4'h8, "R6 bad mode", cmd_status, 8);
    cmd(8'h48, 8'd1);
    check(cmd_status == 4'h4 && slot_state[1:0] == 1, "R7 refused", cmd_status, 4);
    cmd(8'h3F, 8'd2);
    check(latch_open[1] && presence[3:2] == 3 && evt_latch[1] && evt_pres[1], "R9 turn off",
          latch_open[1], 1);
    cmd(8'h0F, 8'd1);
    check(latch_open[0] && evt_pres[0], "R9 turn off slot0", latch_open[0], 1);
    pulse(1'b0, 2'b00, 8'h00, 8'h00, 4'b0100, 4'b0011, 1'b0);
    cmd(8'h49, 8'd1);
    check(slot_state == 8'hEF && pwr_ind == 8'hDF, "R8 enable all", {slot_state, pwr_ind},
          16'hEFDF);
    cmd(8'h4A, 8'd1);
    check(cmd_status == 4'h4, "R12 undefined code", cmd_status, 4);
    pulse(1'b1, 2'b00, 8'h06, 8'd1, '0, '0, 1'b1);
    check(cmd_detected == 0 && slot_state[1:0] == 3, "R11 no byte enable", cmd_detected, 0);
    pulse(1'b1, 2'b10, 8'h00, 8'd3, '0, '0, 1'b1);
    check(cmd_status == 4'h4 && cmd_detected, "R11 target-only write reuses code", cmd_status, 4);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] cd;
      cd = ($urandom % 4 == 0) ? 8'(8'h40 + $urandom % 12) : 8'($urandom % 64);
      if ($urandom % 16 == 0) cd = 8'($urandom);
      pulse(($urandom % 4) != 0, 2'($urandom), cd, 8'($urandom % 7),
            4'(($urandom % 5 == 0) ? $urandom : 0), 4'(($urandom % 4 == 0) ? $urandom : 0),
            ($urandom % 5) == 0);
    end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule